// File: doc/BRIEF.md
# Sector Erase Command Sequencer

This block watches the write strobes that reach a flash device's command decoder. Each strobe carries an address and a data byte. The block looks for the six-write sector-erase sequence: three unlock writes, then a two-write unlock pair, then the erase code. When the last write matches, the block latches the target sector from that write's address and raises a one-clock erase-start pulse for the erase engine.

Any write that does not fit the expected step sends the sequence back to the beginning. A write of the first unlock pattern always counts as a fresh first step, including when it breaks a sequence that was already under way. Cycles with no write strobe leave the progress unchanged.

The state machine has six states. `S_IDLE` waits for write 1. `S_GOT1` waits for write 2, `S_GOT2` for write 3, `S_GOT3` for write 4, `S_GOT4` for write 5, and `S_GOT5` for the erase code. The transitions are:

- **advance**: a matching write moves the machine to the next state.
- **fire**: a matching write in `S_GOT5` returns the machine to `S_IDLE` and starts the erase.
- **restart**: a non-matching write that carries the first unlock pattern goes to `S_GOT1`.
- **abort**: any other non-matching write goes to `S_IDLE`.
- **hold**: with no strobe, the state does not change.

Top module: `erase_seq_top`

## Requirements
- R1: Reset forces `erase_go` to 0, `erase_sector` to 0, and the sequence back to its first step. A sequence that is cut by reset cannot complete with its remaining writes.
- R2: The six writes are: (1) address 5555h, data AAh; (2) 2AAAh, 55h; (3) 5555h, 80h; (4) 5555h, AAh; (5) 2AAAh, 55h; (6) any address, data 30h. After the sixth write is sampled, `erase_go` is 1 for exactly the following clock cycle.
- R3: `erase_sector` takes address bits 15:12 of the sixth write in the same cycle that `erase_go` rises. At all other times it holds its value.
- R4: For writes 1 to 5, address bit 15 is ignored. Only address bits 14:0 are compared.
- R5: On the sixth write, address bits 11:0 do not affect whether the write matches.
- R6: A write whose address or data does not match the expected step aborts the sequence. Completing the remaining steps after an abort gives no pulse.
- R7: A non-matching write that is itself 5555h/AAh counts as write 1 of a new sequence.
- R8: Cycles with `wr_en` low do not change the sequence progress and never cause a pulse.
- R9: A sixth write with data other than 30h gives no pulse.
- R10: A write in the cycle right after the sixth write can be write 1 of a new sequence, so two complete sequences can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle when high |
| wr_addr | input | ADDR_W (16) | Write address |
| wr_data | input | DATA_W (8) | Write data byte |
| erase_go | output | 1 | One-cycle erase-start pulse |
| erase_sector | output | SEC_W (4) | Latched sector number of the last erase |

## Verification
The erase-start pulse of a completed sequence and the acceptance of a new write 1 can fall in the same cycle. The bench provokes this by issuing two full sequences back to back with no idle cycle between them, and again in the random phase, where correct next steps are favoured. A bench reference model predicts, for every cycle, the pulse and the sector. It must see the second sequence fire on its own sixth write, with the new sector, while the first sector stays stable in between.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_GOT1 = 3'd1,
        S_GOT2 = 3'd2,
        S_GOT3 = 3'd3,
        S_GOT4 = 3'd4,
        S_GOT5 = 3'd5
    } seq_state_t;

    localparam int UNLOCK_STEPS = 5;
    localparam logic [7:0] ERASE_CODE = 8'h30;

    function automatic logic [15:0] unlock_addr(input int k);
        case (k)
            1, 4:    unlock_addr = 16'h2AAA;
            default: unlock_addr = 16'h5555;
        endcase
    endfunction

    function automatic logic [7:0] unlock_data(input int k);
        case (k)
            1, 4:    unlock_data = 8'h55;
            2:       unlock_data = 8'h80;
            default: unlock_data = 8'hAA;
        endcase
    endfunction

endpackage

// File: rtl/erase_seq_match.sv
module erase_seq_match
    import erase_seq_pkg::*;
#(
    parameter int CMP_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic [CMP_W-1:0]        cmp_addr,
    input  logic [DATA_W-1:0]       data,
    output logic [UNLOCK_STEPS:0]   hit
);
    for (genvar k = 0; k < UNLOCK_STEPS; k++) begin : g_unlock
        localparam logic [15:0] A = unlock_addr(k);
        localparam logic [7:0]  D = unlock_data(k);
        assign hit[k] = (cmp_addr == A[CMP_W-1:0]) && (data == DATA_W'(D));
    end

    assign hit[UNLOCK_STEPS] = (data == DATA_W'(ERASE_CODE));
endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
    import erase_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [UNLOCK_STEPS:0]  hit,
    output logic                   fire
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                S_IDLE: state_d = hit[0] ? S_GOT1 : S_IDLE;
                S_GOT1: state_d = hit[1] ? S_GOT2 : (hit[0] ? S_GOT1 : S_IDLE);
                S_GOT2: state_d = hit[2] ? S_GOT3 : (hit[0] ? S_GOT1 : S_IDLE);
                S_GOT3: state_d = hit[3] ? S_GOT4 : S_IDLE;
                S_GOT4: state_d = hit[4] ? S_GOT5 : (hit[0] ? S_GOT1 : S_IDLE);
                S_GOT5: begin
                    if (hit[5]) begin
                        state_d = S_IDLE;
                        fire    = 1'b1;
                    end else begin
                        state_d = hit[0] ? S_GOT1 : S_IDLE;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/erase_seq_out.sv
module erase_seq_out #(
    parameter int SEC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [SEC_W-1:0] sec_in,
    output logic             erase_go,
    output logic [SEC_W-1:0] erase_sector
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_go     <= 1'b0;
            erase_sector <= '0;
        end else begin
            erase_go <= fire;
            if (fire) erase_sector <= sec_in;
        end
    end
endmodule

// File: rtl/erase_seq_top.sv
module erase_seq_top
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              erase_go,
    output logic [SEC_W-1:0]  erase_sector
);
    localparam int CMP_W   = ADDR_W - 1;
    localparam int SEC_LSB = ADDR_W - SEC_W;

    logic [UNLOCK_STEPS:0] hit;
    logic                  fire;

    erase_seq_match #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_match (
        .cmp_addr (wr_addr[CMP_W-1:0]),
        .data     (wr_data),
        .hit      (hit)
    );

    erase_seq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .hit   (hit),
        .fire  (fire)
    );

    erase_seq_out #(.SEC_W(SEC_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fire),
        .sec_in       (wr_addr[SEC_LSB +: SEC_W]),
        .erase_go     (erase_go),
        .erase_sector (erase_sector)
    );
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
    parameter int DATA_W = 8,
    parameter int SEC_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEC_W-1:0]  wr_sec,
    input logic [DATA_W-1:0] wr_data,
    input logic              erase_go,
    input logic [SEC_W-1:0]  erase_sector
);
    // R2: the pulse lasts one cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !erase_go);

    // R3: the sector comes from the sixth write
    p_sector_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> erase_sector == $past(wr_sec));

    // R3: the sector holds without a pulse
    p_sector_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_go |-> $stable(erase_sector));

    // R8: no strobe, no pulse
    p_go_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> !erase_go);

    // R9: a pulse needs the erase code
    p_go_needs_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> $past(wr_data) == DATA_W'(8'h30));
endmodule

bind erase_seq_top erase_seq_chk #(.DATA_W(DATA_W), .SEC_W(SEC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sec       (wr_addr[ADDR_W-SEC_W +: SEC_W]),
    .wr_data      (wr_data),
    .erase_go     (erase_go),
    .erase_sector (erase_sector)
);

// File: tb/sim_erase_seq_top.sv
module sim_erase_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        erase_go;
    logic [3:0]  erase_sector;

    int n_vec = 0;
    int n_bad = 0;
    int m_step = 0;
    logic       m_go = 1'b0;
    logic [3:0] m_sec = '0;

    always #5 clk = ~clk;

    erase_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .erase_go(erase_go), .erase_sector(erase_sector)
    );

    function automatic logic [15:0] ref_addr(input int s);
        return (s == 1 || s == 4) ? 16'h2AAA : 16'h5555;
    endfunction

    function automatic logic [7:0] ref_data(input int s);
        return (s == 1 || s == 4) ? 8'h55 : (s == 2 ? 8'h80 : (s == 5 ? 8'h30 : 8'hAA));
    endfunction

    function automatic bit step_ok(input int s, input logic [15:0] a, input logic [7:0] d);
        if (s == 5) return d == 8'h30;
        return (a[14:0] == ref_addr(s)[14:0]) && d == ref_data(s);
    endfunction

    task automatic check(input string tag);
        n_vec++;
        if (erase_go !== m_go || erase_sector !== m_sec) begin
            n_bad++;
            $display("FAIL %s: go=%0b sec=%0h, expected go=%0b sec=%0h",
                     tag, erase_go, erase_sector, m_go, m_sec);
        end
    endtask

    // one cycle: update the model from the stimulus, clock it, compare
    task automatic cyc(input bit en, input logic [15:0] a, input logic [7:0] d, input string tag);
        m_go = 1'b0;
        if (en) begin
            if (step_ok(m_step, a, d)) begin
                if (m_step == 5) begin m_go = 1'b1; m_sec = a[15:12]; m_step = 0; end
                else m_step++;
            end else begin
                m_step = step_ok(0, a, d) ? 1 : 0;
            end
        end
        wr_en = en; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_step = 0; m_go = 1'b0; m_sec = '0;
    endtask

    // full sequence; hi15 sets bit 15 on unlock writes
    task automatic seq(input logic [3:0] sec, input bit hi15, input logic [11:0] low, input string tag);
        for (int s = 0; s < 5; s++)
            cyc(1'b1, ref_addr(s) | (hi15 ? 16'h8000 : 16'h0), ref_data(s), tag);
        cyc(1'b1, {sec, low}, 8'h30, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        check("R1 reset state");

        seq(4'h7, 1'b0, 12'h000, "R2 basic");
        cyc(1'b0, 16'h0, 8'h0, "R2 pulse ends");
        seq(4'hC, 1'b1, 12'h000, "R4 bit15 ignored");
        cyc(1'b0, 16'h0, 8'h0, "R3 hold");
        seq(4'h3, 1'b0, 12'hABC, "R5 low bits ignored");

        // R6: wrong data at step 3, then remaining steps
        for (int s = 0; s < 2; s++) cyc(1'b1, ref_addr(s), ref_data(s), "R6");
        cyc(1'b1, 16'h5555, 8'h81, "R6 wrong data");
        for (int s = 3; s < 5; s++) cyc(1'b1, ref_addr(s), ref_data(s), "R6");
        cyc(1'b1, 16'h9000, 8'h30, "R6 no pulse");
        // R6: wrong address at step 2
        cyc(1'b1, 16'h5555, 8'hAA, "R6");
        cyc(1'b1, 16'h2AAB, 8'h55, "R6 wrong addr");

        // R7: 5555/AA in the step-2 slot restarts as step 1
        cyc(1'b1, 16'h5555, 8'hAA, "R7");
        cyc(1'b1, 16'h5555, 8'hAA, "R7 restart");
        for (int s = 1; s < 5; s++) cyc(1'b1, ref_addr(s), ref_data(s), "R7");
        cyc(1'b1, 16'hE123, 8'h30, "R7 pulse");

        // R8: idle gaps between every write
        for (int s = 0; s < 5; s++) begin
            cyc(1'b1, ref_addr(s), ref_data(s), "R8");
            cyc(1'b0, 16'h2AAA, 8'h30, "R8 gap");
            cyc(1'b0, 16'h5555, 8'hAA, "R8 gap");
        end
        cyc(1'b1, 16'h5000, 8'h30, "R8 pulse");

        // R9: wrong erase code
        for (int s = 0; s < 5; s++) cyc(1'b1, ref_addr(s), ref_data(s), "R9");
        cyc(1'b1, 16'h9000, 8'h31, "R9 no pulse");

        // R10: back to back
        seq(4'hA, 1'b0, 12'h000, "R10 first");
        seq(4'h1, 1'b0, 12'h555, "R10 second");

        // R1: reset mid-sequence
        for (int s = 0; s < 3; s++) cyc(1'b1, ref_addr(s), ref_data(s), "R1");
        do_reset();
        check("R1 after reset");
        for (int s = 3; s < 5; s++) cyc(1'b1, ref_addr(s), ref_data(s), "R1");
        cyc(1'b1, 16'h4000, 8'h30, "R1 no pulse");

        // random phase, biased toward the correct next step
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            logic [15:0] a = 16'($urandom);
            logic [7:0]  d = 8'($urandom);
            if (r < 65) begin
                if (m_step < 5) a = ref_addr(m_step) | (a & 16'h8000);
                d = ref_data(m_step);
            end else if (r < 75) begin
                a = 16'h5555; d = 8'hAA;
            end
            cyc(r < 90, a, d, "R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule